// File: doc/BRIEF.md
# Register-Programmed Memory Copy Engine

This block copies a run of 32-bit words from one region of memory to another. Software sets it up through a small write/read register port. It writes a source address and a destination address, then writes a byte count, and that last write launches the copy. The engine then alternates on two simple handshake ports. It issues a read request at the current source address and waits for the returned word. It then issues a write request carrying that word to the current destination address and waits for the acknowledge. After each word it advances both addresses by four and lowers the remaining count by four.

A status register reports whether the engine is idle. A soft-reset bit in the control register aborts any copy in progress and clears the programmed registers. Addresses and counts are handled as whole words: the two low bits of every programmed address and count are discarded.

Top module: `mem_copy_engine`

## Requirements
- R1: After reset no read or write request is raised. The status register (offset 0x04) reads 0x2, meaning bit 1 = idle. The control (0x00), source (0x18), destination (0x20) and count (0x28) registers read zero.
- R2: A write to offset 0x18 or 0x20 while idle stores the address with bits [1:0] forced to zero, and the stored value reads back at the same offset. Such writes made while a copy runs are ignored.
- R3: While idle, a write to offset 0x28 with a nonzero word-rounded value (bits [CW-1:2] not all zero) starts a copy. From the next cycle, status bit 1 reads 0.
- R4: A count write whose word-rounded value is zero (for example 0 or 3) starts nothing. The engine stays idle and the count reads zero.
- R5: Each word is first read at the current source address. The returned word is then written to the current destination address. After each write acknowledge, source and destination each advance by 4 and the count register drops by 4.
- R6: A read request holds with a stable address until the cycle in which read-valid is high, and the data is captured in that cycle. A valid in the same cycle as the request is allowed.
- R7: A write request holds with stable address and data until the cycle in which write-acknowledge is high. Read and write requests are never high together.
- R8: Once the last word is acknowledged, the engine returns to idle. The count reads zero, and source and destination read their start values plus the byte count.
- R9: Count writes made while a copy is running are ignored. The copy finishes with its original length.
- R10: A control write with bit 2 set aborts any copy. From the next cycle there are no requests, the engine is idle, and source, destination and count read zero. Control reads back as zero, because the bit clears itself. A fresh copy works afterwards.
- R11: A control write with bit 2 clear has no effect on a running or an idle engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | RAW | Register write byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | RAW | Register read byte offset |
| cfg_rdata | output | 32 | Register read data (combinational) |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read word address |
| rd_valid | input | 1 | Read data valid, completes the read |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | AW | Memory write word address |
| wr_data | output | 32 | Memory write data |
| wr_ack | input | 1 | Write acknowledge, completes the write |

## Verification
The assertions check the handshake discipline on every cycle. They cover holding read and write requests stable until completion, never raising both requests together, and forwarding the read word into the following write. They also cover the 4-byte address step after each acknowledge, the busy indication in status, and the request drop after a soft reset. Other behaviours are visible only through the bench's scenarios against its reference model. These include the exact final register values after a copy, the ignoring of count and address writes during a copy, and the rejection of zero-length starts. They also include full-length copies of 2704 and 3176 bytes under varied memory latencies, and restarting after an abort.

// File: rtl/mem_copy_engine.sv
module mem_copy_engine #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int RAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [RAW-1:0] cfg_waddr,
  input  logic [31:0]    cfg_wdata,
  input  logic [RAW-1:0] cfg_raddr,
  output logic [31:0]    cfg_rdata,
  output logic           rd_req,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_valid,
  input  logic [31:0]    rd_data,
  output logic           wr_req,
  output logic [AW-1:0]  wr_addr,
  output logic [31:0]    wr_data,
  input  logic           wr_ack
);

  localparam logic [RAW-1:0] OFF_CTRL = RAW'('h00);
  localparam logic [RAW-1:0] OFF_STAT = RAW'('h04);
  localparam logic [RAW-1:0] OFF_SRC  = RAW'('h18);
  localparam logic [RAW-1:0] OFF_DST  = RAW'('h20);
  localparam logic [RAW-1:0] OFF_LEN  = RAW'('h28);
  localparam logic [AW-1:0]  STEP_A   = AW'(4);
  localparam logic [CW-1:0]  STEP_C   = CW'(4);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;

  state_t         state_q;
  logic [AW-1:0]  src_q, dst_q;
  logic [CW-1:0]  remain_q;
  logic [31:0]    hold_q;

  logic           idle, soft_rst, load_src, load_dst, start;
  logic [CW-1:0]  len_in;

  assign idle     = (state_q == S_IDLE);
  assign soft_rst = cfg_we && (cfg_waddr == OFF_CTRL) && cfg_wdata[2];
  assign load_src = cfg_we && (cfg_waddr == OFF_SRC) && idle;
  assign load_dst = cfg_we && (cfg_waddr == OFF_DST) && idle;
  assign len_in   = {cfg_wdata[CW-1:2], 2'b00};
  assign start    = cfg_we && (cfg_waddr == OFF_LEN) && idle && (len_in != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      remain_q <= '0;
      hold_q   <= '0;
    end else if (soft_rst) begin
      state_q  <= S_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      remain_q <= '0;
      hold_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (load_src) src_q <= {cfg_wdata[AW-1:2], 2'b00};
          if (load_dst) dst_q <= {cfg_wdata[AW-1:2], 2'b00};
          if (start) begin
            remain_q <= len_in;
            state_q  <= S_READ;
          end
        end
        S_READ: begin
          if (rd_valid) begin
            hold_q  <= rd_data;
            state_q <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (wr_ack) begin
            src_q    <= src_q + STEP_A;
            dst_q    <= dst_q + STEP_A;
            remain_q <= remain_q - STEP_C;
            state_q  <= (remain_q == STEP_C) ? S_IDLE : S_READ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req  = (state_q == S_READ);
  assign rd_addr = src_q;
  assign wr_req  = (state_q == S_WRITE);
  assign wr_addr = dst_q;
  assign wr_data = hold_q;

  always_comb begin
    case (cfg_raddr)
      OFF_STAT: cfg_rdata = {30'd0, idle, 1'b0};
      OFF_SRC:  cfg_rdata = 32'(src_q);
      OFF_DST:  cfg_rdata = 32'(dst_q);
      OFF_LEN:  cfg_rdata = 32'(remain_q);
      default:  cfg_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/mem_copy_engine_chk.sv
module mem_copy_engine_chk #(
  parameter int AW  = 32,
  parameter int RAW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic [RAW-1:0] cfg_waddr,
  input logic           ctl_bit,
  input logic [RAW-1:0] cfg_raddr,
  input logic [31:0]    cfg_rdata,
  input logic           rd_req,
  input logic [AW-1:0]  rd_addr,
  input logic           rd_valid,
  input logic [31:0]    rd_data,
  input logic           wr_req,
  input logic [AW-1:0]  wr_addr,
  input logic [31:0]    wr_data,
  input logic           wr_ack
);

  logic abort;
  assign abort = cfg_we && (cfg_waddr == '0) && ctl_bit;

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid && !abort) |=> (rd_req && $stable(rd_addr)));

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack && !abort) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid && !abort) |=> (wr_req && wr_data == $past(rd_data)));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ack && !abort) |=>
      (rd_addr == $past(rd_addr) + AW'(4) && wr_addr == $past(wr_addr) + AW'(4)));

  assert_busy_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_req || wr_req) && cfg_raddr == RAW'('h04)) |-> !cfg_rdata[1]);

  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!rd_req && !wr_req));

endmodule

bind mem_copy_engine mem_copy_engine_chk #(.AW(AW), .RAW(RAW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
  .ctl_bit(cfg_wdata[2]), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
  .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack)
);

// File: tb/mem_copy_engine_tb_top.sv
module mem_copy_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int RAW = 6;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic           cfg_we = 1'b0;
  logic [RAW-1:0] cfg_waddr = '0;
  logic [31:0]    cfg_wdata = '0;
  logic [RAW-1:0] cfg_raddr = '0;
  logic [31:0]    cfg_rdata;
  logic           rd_req;
  logic [AW-1:0]  rd_addr;
  logic           rd_valid = 1'b0;
  logic [31:0]    rd_data = '0;
  logic           wr_req;
  logic [AW-1:0]  wr_addr;
  logic [31:0]    wr_data;
  logic           wr_ack = 1'b0;

  mem_copy_engine #(.AW(AW), .CW(CW), .RAW(RAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m_phase = 0;
  logic [31:0] m_src = 0, m_dst = 0, m_buf = 0;
  int m_cnt = 0;
  int rlat_max = 0, wlat_max = 0, rlat = 0, wlat = 0;
  int force_raddr = -1;
  logic [31:0] dmem [logic [31:0]];

  function automatic logic [31:0] src_word(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] exp_reg(logic [RAW-1:0] a);
    case (a)
      6'h04: return (m_phase == 0) ? 32'h2 : 32'h0;
      6'h18: return m_src;
      6'h20: return m_dst;
      6'h28: return 32'(m_cnt);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic compare_all();
    check("R6 rd_req", 32'(rd_req), 32'(m_phase == 1));
    if (m_phase == 1) check("R6 rd_addr", rd_addr, m_src);
    check("R7 wr_req", 32'(wr_req), 32'(m_phase == 2));
    if (m_phase == 2) begin
      check("R5 wr_addr", wr_addr, m_dst);
      check("R5 wr_data", wr_data, m_buf);
    end
    check("R2 register readback", cfg_rdata, exp_reg(cfg_raddr));
  endtask

  task automatic model_step();
    if (!rst_n || (cfg_we && cfg_waddr == 6'h00 && cfg_wdata[2])) begin
      m_phase = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_buf = 0;
      return;
    end
    case (m_phase)
      0: if (cfg_we) begin
           if (cfg_waddr == 6'h18) m_src = cfg_wdata & ~32'h3;
           if (cfg_waddr == 6'h20) m_dst = cfg_wdata & ~32'h3;
           if (cfg_waddr == 6'h28) begin
             int n = int'(cfg_wdata[15:0] & 16'hFFFC);
             if (n != 0) begin m_cnt = n; m_phase = 1; end
           end
         end
      1: if (rd_valid) begin m_buf = src_word(m_src); m_phase = 2; end
      default: if (wr_ack) begin
           dmem[m_dst] = m_buf;
           m_src += 4; m_dst += 4; m_cnt -= 4;
           m_phase = (m_cnt == 0) ? 0 : 1;
         end
    endcase
  endtask

  task automatic cycle(logic we, logic [RAW-1:0] wa, logic [31:0] wd);
    @(negedge clk);
    cyc++;
    if (cyc > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
    if (rst_n) compare_all();
    cfg_we = we; cfg_waddr = wa; cfg_wdata = wd;
    if (force_raddr >= 0) cfg_raddr = RAW'(force_raddr);
    else case (cyc % 5)
      0: cfg_raddr = 6'h00; 1: cfg_raddr = 6'h04; 2: cfg_raddr = 6'h18;
      3: cfg_raddr = 6'h20; default: cfg_raddr = 6'h28;
    endcase
    rd_valid = rd_req && (rlat >= rlat_max);
    rd_data  = rd_req ? src_word(rd_addr) : 32'h0;
    rlat     = (rd_req && !rd_valid) ? rlat + 1 : 0;
    wr_ack   = wr_req && (wlat >= wlat_max);
    wlat     = (wr_req && !wr_ack) ? wlat + 1 : 0;
    @(posedge clk);
    model_step();
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, '0, '0);
  endtask

  task automatic wr(logic [RAW-1:0] a, logic [31:0] d);
    cycle(1'b1, a, d);
  endtask

  task automatic peek(string tag, logic [RAW-1:0] a, logic [31:0] exp);
    force_raddr = int'(a);
    cycle(1'b0, '0, '0);
    force_raddr = -1;
    #(CLK_PERIOD/4);
    check(tag, cfg_rdata, exp);
  endtask

  task automatic wait_idle();
    while (m_phase != 0) cycle(1'b0, '0, '0);
    idle_cycles(1);
  endtask

  task automatic check_copy(string tag, logic [31:0] s, logic [31:0] d, int nbytes);
    for (int i = 0; i < nbytes / 4; i++) begin
      logic [31:0] a = d + 32'(4 * i);
      check(tag, dmem.exists(a) ? dmem[a] : 32'hDEADDEAD, src_word(s + 32'(4 * i)));
    end
  endtask

  task automatic copy(logic [31:0] s, logic [31:0] d, int nbytes);
    wr(6'h18, s);
    wr(6'h20, d);
    wr(6'h28, 32'(nbytes));
  endtask

  initial begin
    idle_cycles(3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    peek("R1 status idle", 6'h04, 32'h2);
    peek("R1 control", 6'h00, 32'h0);
    peek("R1 source", 6'h18, 32'h0);
    peek("R1 destination", 6'h20, 32'h0);
    peek("R1 count", 6'h28, 32'h0);
    check("R1 no requests", 32'(rd_req || wr_req), 32'h0);

    // R2 low bits dropped
    wr(6'h18, 32'h1000_0003);
    peek("R2 source aligned", 6'h18, 32'h1000_0000);
    wr(6'h20, 32'h2000_0002);
    peek("R2 destination aligned", 6'h20, 32'h2000_0000);

    // R3 start, zero latency
    wr(6'h28, 32'd8);
    peek("R3 busy status", 6'h04, 32'h0);
    wait_idle();
    peek("R8 idle after copy", 6'h04, 32'h2);
    peek("R8 count zero", 6'h28, 32'h0);
    peek("R8 source end", 6'h18, 32'h1000_0008);
    peek("R8 destination end", 6'h20, 32'h2000_0008);
    check_copy("R5 copied data 8B", 32'h1000_0000, 32'h2000_0000, 8);

    // R6 R7 with handshake latency
    rlat_max = 2; wlat_max = 3;
    copy(32'h1000_0100, 32'h2000_1000, 16);
    wait_idle();
    check_copy("R6 R7 copied data 16B", 32'h1000_0100, 32'h2000_1000, 16);

    // R4 zero-length starts
    wr(6'h28, 32'd0);
    peek("R4 zero stays idle", 6'h04, 32'h2);
    check("R4 no read after zero", 32'(rd_req), 32'h0);
    wr(6'h28, 32'd3);
    peek("R4 sub-word stays idle", 6'h04, 32'h2);
    peek("R4 count stays zero", 6'h28, 32'h0);

    // R9 and R2: writes during a copy are ignored
    rlat_max = 1; wlat_max = 0;
    copy(32'h3000_0000, 32'h4000_0000, 2704);
    idle_cycles(5);
    wr(6'h28, 32'd8);
    wr(6'h18, 32'h5000_0000);
    wr(6'h20, 32'h5100_0000);
    wait_idle();
    peek("R9 source end after full length", 6'h18, 32'h3000_0000 + 32'd2704);
    peek("R2 destination unaffected while busy", 6'h20, 32'h4000_0000 + 32'd2704);
    check_copy("R9 copied data 2704B", 32'h3000_0000, 32'h4000_0000, 2704);

    // R11 control write without bit 2
    rlat_max = 0; wlat_max = 1;
    copy(32'h3100_0000, 32'h4100_0000, 3176);
    idle_cycles(7);
    wr(6'h00, 32'h3);
    wr(6'h00, 32'h8);
    peek("R11 still busy", 6'h04, 32'h0);
    wait_idle();
    peek("R11 count end", 6'h28, 32'h0);
    check_copy("R11 copied data 3176B", 32'h3100_0000, 32'h4100_0000, 3176);

    // R10 soft reset mid-copy
    rlat_max = 2; wlat_max = 1;
    copy(32'h5000_0000, 32'h6000_0000, 64);
    idle_cycles(9);
    wr(6'h00, 32'h4);
    peek("R10 idle after abort", 6'h04, 32'h2);
    check("R10 requests dropped", 32'(rd_req || wr_req), 32'h0);
    peek("R10 source cleared", 6'h18, 32'h0);
    peek("R10 destination cleared", 6'h20, 32'h0);
    peek("R10 count cleared", 6'h28, 32'h0);
    peek("R10 control self-clears", 6'h00, 32'h0);
    copy(32'h0000_0100, 32'h0000_0200, 8);
    wait_idle();
    check_copy("R10 copy after abort", 32'h0000_0100, 32'h0000_0200, 8);

    idle_cycles(3);
    summary();
    $finish;
  end
endmodule